// File: doc/BRIEF.md
# Framed Byte and Packet Receiver

This block sits behind a bit-level line decoder. It takes a stream of decoded bits and an abort strobe, and turns them into framed bytes and whole packets. While hunting, it watches the recent bits for a lead-in of four ones followed by a zero. That zero is also the start bit of the first byte frame. Each frame then carries eleven bits: a start bit, eight data bits least significant first, an odd parity bit and a stop bit.

The first byte of every packet is a header. The header value sets how many message bytes follow, and one checksum byte comes after them. Every completed frame is presented as one beat on a valid/ready output stream. The beat carries the data byte and its three framing error flags. It also carries the packet header, the 1-based position of the byte in the packet, a last-byte marker and, on the last byte, the result of the XOR checksum.

Input bits arrive on a valid/ready stream. A bit is taken only in a cycle where `in_valid` and `in_ready` are both high and `abort` is low. `in_ready` is low exactly while a beat is held on the output and `out_ready` is low. No bit is therefore lost when the consumer stalls, and the back-pressure reaches the bit source at once. An output beat, once raised, holds all of its fields steady until it is accepted.

Top module: `frame_pkt_rx`

## Requirements
- R1: While hunting, the receiver enters the frame state when the five most recent accepted bits are 1,1,1,1,0, oldest first. That zero is the start bit of the first frame. Bits accepted while hunting never produce an output beat.
- R2: A frame is 11 accepted bits: start, eight data bits least significant first, parity, stop. The beat appears on `out_data` in the cycle after the eleventh bit is accepted.
- R3: `out_par_err` is 1 when the parity bit differs from 1 XOR the XOR of the eight data bits, so parity is odd.
- R4: `out_start_err` is 1 when the start bit is 1. `out_stop_err` is 1 when the stop bit is 0. A byte with any framing error is still delivered and still counts toward its packet.
- R5: The header h sets the message length. For h below 0x20 it is 1. For 0x20 to 0x7F it is 2+(h-32)/16. For 0x80 to 0xDF it is 8+(h-128)/8. For 0xE0 to 0xFF it is 20+(h-224)/4, using integer division. The packet holds that length plus 2 bytes.
- R6: Every beat carries the packet's header on `out_hdr` and its 1-based position on `out_count`. `out_last` is 1 exactly on the beat whose position equals the packet length.
- R7: On the last beat, `out_cksum_ok` is 1 when the XOR of all earlier bytes of the packet equals the last byte. It is 0 otherwise and on every other beat.
- R8: `abort` returns the receiver to hunting and discards the partial frame, the partial packet and the lead-in history. A bit offered in the same cycle is dropped. A beat already on the output is kept.
- R9: An output beat with `out_ready` low keeps every field unchanged in the next cycle. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R10: After a packet completes, the receiver stays in the frame state. The next 11 bits form the header frame of a new packet, with no new lead-in.
- R11: After reset, `out_valid` is 0, `in_ready` is 1 and the receiver is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded bit is offered |
| in_ready | output | 1 | The receiver can take the offered bit |
| in_bit | input | 1 | Decoded bit value |
| abort | input | 1 | Strobe from the line decoder: drop back to hunting |
| out_valid | output | 1 | A completed byte beat is presented |
| out_ready | input | 1 | The consumer takes the beat |
| out_data | output | 8 | Received data byte |
| out_start_err | output | 1 | Start bit was 1 |
| out_par_err | output | 1 | Odd parity failed |
| out_stop_err | output | 1 | Stop bit was 0 |
| out_last | output | 1 | Byte is the checksum byte of its packet |
| out_hdr | output | 8 | Header byte of the current packet |
| out_count | output | 5 | 1-based position of the byte in the packet |
| out_cksum_ok | output | 1 | Checksum matched (last beat only) |

## Verification
The bench targets the edges of every header range: 0x1F, 0x20, 0x7F, 0x80, 0xDF, 0xE0 and 0xFF. A wrong length formula would set `out_last` one byte early or late, and every packet after it would lose alignment. It sends packets back to back with no new lead-in, where a receiver that drops to hunting would go silent. It injects start, parity and stop errors, where a receiver that discards the bad byte would shift the position count. It sends a corrupted checksum, and an abort in mid-packet followed by bits with no lead-in, which must give no beats. Random consumer stalls test that beats stay frozen and that no input bit is taken while a beat waits.

// File: rtl/frx_pkg.sv
package frx_pkg;
  parameter int BYTE_W     = 8;
  parameter int FRAME_BITS = BYTE_W + 3;
  parameter int MAX_TOTAL  = 29;
  parameter int PRE_W      = 5;

  localparam int CNT_W  = $clog2(MAX_TOTAL + 1);
  localparam int FCNT_W = $clog2(FRAME_BITS);
  localparam logic [PRE_W-1:0] PRE_PATTERN = {{(PRE_W-1){1'b1}}, 1'b0};

  typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // Whole packet length (header + message + checksum) from a header value.
  function automatic cnt_t total_bytes(input byte_t h);
    byte_t off;
    cnt_t  msg;
    off = '0;
    if (h < byte_t'(8'h20)) begin
      msg = cnt_t'(1);
    end else if (h < byte_t'(8'h80)) begin
      off = h - byte_t'(8'h20);
      msg = cnt_t'(2) + cnt_t'(off >> 4);
    end else if (h < byte_t'(8'hE0)) begin
      off = h - byte_t'(8'h80);
      msg = cnt_t'(8) + cnt_t'(off >> 3);
    end else begin
      off = h - byte_t'(8'hE0);
      msg = cnt_t'(20) + cnt_t'(off >> 2);
    end
    return msg + cnt_t'(2);
  endfunction
endpackage

// File: rtl/frx_preamble.sv
module frx_preamble
  import frx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bit_in,
  input  logic clr,
  output logic hit
);
  logic [PRE_W-1:0] hist_q;
  logic [PRE_W-1:0] hist_d;

  // oldest bit sits in the MSB
  assign hist_d = {hist_q[PRE_W-2:0], bit_in};
  assign hit    = shift_en && (hist_d == PRE_PATTERN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (clr || hit) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_d;
    end
  end
endmodule

// File: rtl/frx_framer.sv
module frx_framer
  import frx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              seed,
  input  logic              take,
  input  logic              bit_in,
  output logic              done,
  output byte_t             data,
  output logic              start_err,
  output logic              par_err,
  output logic              stop_err,
  output logic [FCNT_W-1:0] cnt_o
);
  localparam int HELD = FRAME_BITS - 1;            // bits stored before the stop bit
  localparam logic [FCNT_W-1:0] STOP_IDX = FCNT_W'(HELD);

  logic [HELD-1:0]   sbuf_q;
  logic [FCNT_W-1:0] cnt_q;
  logic              par_bit;

  assign done    = take && (cnt_q == STOP_IDX);
  assign par_bit = sbuf_q[HELD-1];

  // data bits sit at positions 1..BYTE_W, least significant first
  for (genvar i = 0; i < BYTE_W; i++) begin : g_data
    assign data[i] = sbuf_q[i+1];
  end

  assign start_err = sbuf_q[0];
  assign par_err   = (par_bit != ~^data);
  assign stop_err  = !bit_in;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sbuf_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (seed) begin
      sbuf_q[0] <= 1'b0;
      cnt_q     <= FCNT_W'(1);
    end else if (take) begin
      if (done) begin
        cnt_q <= '0;
      end else begin
        sbuf_q[cnt_q] <= bit_in;
        cnt_q         <= cnt_q + FCNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/frx_packet.sv
module frx_packet
  import frx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  byte_en,
  input  byte_t byte_in,
  output logic  last,
  output byte_t hdr,
  output cnt_t  count,
  output logic  cksum_ok
);
  cnt_t  idx_q;
  cnt_t  total_q;
  byte_t hdr_q;
  byte_t xacc_q;
  cnt_t  total;
  logic  is_head;

  assign is_head  = (idx_q == '0);
  assign total    = is_head ? total_bytes(byte_in) : total_q;
  assign hdr      = is_head ? byte_in : hdr_q;
  assign count    = idx_q + cnt_t'(1);
  assign last     = byte_en && !is_head && (count == total);
  assign cksum_ok = last && (xacc_q == byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      total_q <= '0;
      hdr_q   <= '0;
      xacc_q  <= '0;
    end else if (clr) begin
      idx_q  <= '0;
      xacc_q <= '0;
    end else if (byte_en) begin
      if (last) begin
        idx_q  <= '0;
        xacc_q <= '0;
      end else begin
        idx_q  <= count;
        xacc_q <= xacc_q ^ byte_in;
        if (is_head) begin
          total_q <= total;
          hdr_q   <= byte_in;
        end
      end
    end
  end
endmodule

// File: rtl/frame_pkt_rx.sv
module frame_pkt_rx
  import frx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              abort,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_start_err,
  output logic              out_par_err,
  output logic              out_stop_err,
  output logic              out_last,
  output logic [BYTE_W-1:0] out_hdr,
  output logic [CNT_W-1:0]  out_count,
  output logic              out_cksum_ok
);
  rx_state_e         state_q;
  logic              accept;
  logic              hunting;
  logic              pre_hit;
  logic              f_done;
  byte_t             f_data;
  logic              f_serr;
  logic              f_perr;
  logic              f_terr;
  logic [FCNT_W-1:0] f_cnt;
  logic              p_last;
  byte_t             p_hdr;
  cnt_t              p_count;
  logic              p_ok;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready && !abort;
  assign hunting  = (state_q == ST_HUNT);

  frx_preamble u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept && hunting),
    .bit_in   (in_bit),
    .clr      (abort),
    .hit      (pre_hit)
  );

  frx_framer u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (abort),
    .seed      (pre_hit),
    .take      (accept && !hunting),
    .bit_in    (in_bit),
    .done      (f_done),
    .data      (f_data),
    .start_err (f_serr),
    .par_err   (f_perr),
    .stop_err  (f_terr),
    .cnt_o     (f_cnt)
  );

  frx_packet u_pkt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (abort),
    .byte_en  (f_done),
    .byte_in  (f_data),
    .last     (p_last),
    .hdr      (p_hdr),
    .count    (p_count),
    .cksum_ok (p_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
    end else if (abort) begin
      state_q <= ST_HUNT;
    end else if (pre_hit) begin
      state_q <= ST_FRAME;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_start_err <= 1'b0;
      out_par_err   <= 1'b0;
      out_stop_err  <= 1'b0;
      out_last      <= 1'b0;
      out_hdr       <= '0;
      out_count     <= '0;
      out_cksum_ok  <= 1'b0;
    end else if (f_done) begin
      out_valid     <= 1'b1;
      out_data      <= f_data;
      out_start_err <= f_serr;
      out_par_err   <= f_perr;
      out_stop_err  <= f_terr;
      out_last      <= p_last;
      out_hdr       <= p_hdr;
      out_count     <= p_count;
      out_cksum_ok  <= p_ok;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // frame bit counter is observed only by the bound checker
  logic unused_cnt;
  assign unused_cnt = ^f_cnt;
endmodule

// File: rtl/frx_chk.sv
module frx_chk
  import frx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              abort,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_data,
  input logic              out_last,
  input logic [CNT_W-1:0]  out_count,
  input logic              out_cksum_ok,
  input logic [FCNT_W-1:0] frame_cnt
);
  // R9
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)
      && $stable(out_count));

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !(out_valid && !out_ready) |=> !out_valid);

  // R6
  last_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_count >= CNT_W'(3));

  // R7
  cksum_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_cksum_ok |-> out_last);

  // R2
  frame_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= FCNT_W'(FRAME_BITS - 1));
endmodule

bind frame_pkt_rx frx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .abort        (abort),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_last     (out_last),
  .out_count    (out_count),
  .out_cksum_ok (out_cksum_ok),
  .frame_cnt    (u_frame.cnt_q)
);

// File: tb/tb_frame_pkt_rx.sv
module tb_frame_pkt_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       abort = 1'b0;
  logic       out_ready = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_start_err, out_par_err, out_stop_err, out_last, out_cksum_ok;
  logic [7:0] out_hdr;
  logic [4:0] out_count;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  frame_pkt_rx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .abort(abort), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_start_err(out_start_err), .out_par_err(out_par_err), .out_stop_err(out_stop_err),
    .out_last(out_last), .out_hdr(out_hdr), .out_count(out_count), .out_cksum_ok(out_cksum_ok)
  );

  // ---------------- reference model ----------------
  bit m_hunt = 1;
  bit hist[$];
  bit frame[$];
  int pkt[$];
  bit m_ov = 0, m_se = 0, m_pe = 0, m_te = 0, m_last = 0, m_ok = 0;
  int m_data = 0, m_hdr = 0, m_cnt = 0;

  function automatic int ref_len(int h);
    if (h <= 31) return 1;
    if (h <= 127) return 2 + (h - 32) / 16;
    if (h <= 223) return 8 + (h - 128) / 8;
    return 20 + (h - 224) / 4;
  endfunction

  function automatic bit model_step(bit v, bit b, bit ab, bit rdy);
    bit acc_rdy = !m_ov || rdy;
    if (m_ov && rdy) m_ov = 0;
    if (ab) begin
      m_hunt = 1; hist.delete(); frame.delete(); pkt.delete();
    end else if (v && acc_rdy) begin
      if (m_hunt) begin
        hist.push_back(b);
        if (hist.size() > 5) void'(hist.pop_front());
        if (hist.size() == 5 && hist[0] && hist[1] && hist[2] && hist[3] && !hist[4]) begin
          m_hunt = 0; hist.delete(); frame.delete(); frame.push_back(1'b0);
        end
      end else begin
        frame.push_back(b);
        if (frame.size() == 11) begin
          int val = 0;
          int par = 1;
          for (int k = 0; k < 8; k++) begin
            if (frame[1+k]) val += (1 << k);
            par ^= int'(frame[1+k]);
          end
          m_ov = 1; m_data = val;
          m_se = frame[0]; m_pe = (int'(frame[9]) != par); m_te = !frame[10];
          pkt.push_back(val);
          m_hdr = pkt[0]; m_cnt = pkt.size();
          m_last = (pkt.size() == ref_len(pkt[0]) + 2);
          m_ok = 0;
          if (m_last) begin
            int x = 0;
            for (int i = 0; i < pkt.size() - 1; i++) x ^= pkt[i];
            m_ok = (x == pkt[pkt.size()-1]);
            pkt.delete();
          end
          frame.delete();
        end
      end
    end
    return v && acc_rdy && !ab;
  endfunction

  // ---------------- checks ----------------
  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk(out_valid == m_ov, "R1/R8/R10", "out_valid", out_valid, m_ov);
    if (m_ov && out_valid) begin
      chk(out_data == m_data[7:0], "R2", "out_data", out_data, m_data);
      chk(out_start_err == m_se, "R4", "start_err", out_start_err, m_se);
      chk(out_stop_err == m_te, "R4", "stop_err", out_stop_err, m_te);
      chk(out_par_err == m_pe, "R3", "par_err", out_par_err, m_pe);
      chk(out_last == m_last, "R5", "out_last", out_last, m_last);
      chk(out_hdr == m_hdr[7:0], "R6", "out_hdr", out_hdr, m_hdr);
      chk(int'(out_count) == m_cnt, "R6", "out_count", out_count, m_cnt);
      chk(out_cksum_ok == m_ok, "R7", "cksum_ok", out_cksum_ok, m_ok);
    end
  endtask

  // ---------------- stimulus builders (2 = abort pulse) ----------------
  int stim[$];

  task automatic add_byte(int b, bit skip_start, bit bad_s, bit bad_p, bit bad_t);
    int par = 1;
    if (!skip_start) stim.push_back(bad_s ? 1 : 0);
    for (int k = 0; k < 8; k++) begin
      stim.push_back((b >> k) & 1);
      par ^= (b >> k) & 1;
    end
    stim.push_back(bad_p ? par ^ 1 : par);
    stim.push_back(bad_t ? 0 : 1);
  endtask

  task automatic add_lead(int ones);
    for (int i = 0; i < ones; i++) stim.push_back(1);
    stim.push_back(0);
  endtask

  task automatic add_packet(int hdr, bit after_lead, bit bad_ck, int se_at, int pe_at, int te_at);
    int total = ref_len(hdr) + 2;
    int x = 0;
    for (int i = 0; i < total; i++) begin
      int b;
      if (i == 0) b = hdr;
      else if (i == total - 1) b = bad_ck ? (x ^ 8'h5A) : x;
      else b = int'($urandom_range(0, 255));
      x ^= b;
      add_byte(b, after_lead && i == 0, i == se_at, i == pe_at, i == te_at);
    end
  endtask

  // ---------------- main ----------------
  initial begin
    bit pend = 0;
    bit pbit = 0;
    bit force_rdy = 0;
    int drain = 0;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11", "reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R11", "reset in_ready", in_ready, 1);
    rst_n = 1'b1;

    // R1 noise that never forms the lead-in, then a lead-in with extra ones
    foreach (stim[i]) stim.delete(i);
    stim.push_back(0); stim.push_back(1); stim.push_back(0);
    stim.push_back(1); stim.push_back(1); stim.push_back(1); stim.push_back(0);
    add_lead(6);
    add_packet(8'h01, 1, 0, -1, -1, -1);
    // R10 back to back packets, R5 range edges
    add_packet(8'h1F, 0, 0, -1, -1, -1);
    add_packet(8'h20, 0, 0, -1, -1, -1);
    add_packet(8'h7F, 0, 1, -1, -1, -1);   // R7 corrupted checksum
    add_packet(8'h80, 0, 0, 1, 2, 3);      // R3 R4 framing errors
    add_packet(8'hDF, 0, 0, -1, -1, -1);
    add_packet(8'hE0, 0, 0, -1, -1, -1);
    add_packet(8'hFF, 0, 0, 0, -1, 4);
    // R8 abort mid-packet, then framed bits with no lead-in
    add_byte(8'h04, 0, 0, 0, 0);
    add_byte(8'h33, 0, 0, 0, 0);
    stim.push_back(1); stim.push_back(1);
    stim.push_back(2);
    add_byte(8'h02, 0, 0, 0, 0);
    add_byte(8'h00, 0, 0, 0, 0);
    add_byte(8'h02, 0, 0, 0, 0);
    add_lead(4);
    add_packet(8'hE7, 1, 0, -1, -1, -1);
    add_packet(8'h45, 0, 0, -1, -1, -1);

    while (!finished) begin
      bit rdy, ab, acc;
      @(negedge clk);
      compare_outputs();
      rdy = force_rdy ? 1'b1 : ($urandom_range(0, 3) != 0);
      ab = 0;
      if (!pend && stim.size() > 0) begin
        if (stim[0] == 2) begin
          ab = 1; void'(stim.pop_front());
        end else if ($urandom_range(0, 2) != 0) begin
          pend = 1; pbit = stim.pop_front() != 0;
        end
      end
      in_valid = pend; in_bit = pbit; abort = ab; out_ready = rdy;
      #1;
      // R9 back-pressure on the bit input
      chk(in_ready == (!m_ov || rdy), "R9", "in_ready", in_ready, !m_ov || rdy);
      acc = model_step(pend, pbit, ab, rdy);
      if (acc) pend = 0;
      if (stim.size() == 0 && !pend) begin
        force_rdy = 1;
        drain++;
        if (drain > 60) finished = 1;
      end
    end
    @(negedge clk);
    in_valid = 0; abort = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule